// File: doc/BRIEF.md
# Bus Target-Write Queue Reader

This block holds bus target-write traffic until a controller collects it through a small window of read-only I/O ports. A bus-side producer offers entries over a valid/ready push interface. Each entry carries four things: a kind code, a target number, four byte enables and a 32-bit payload. The payload is a bus address, a read word count or a write data word. Pushes aimed at configuration space or the expansion ROM never enter the queue. They are counted instead.

The controller works in three steps. It reads the occupancy port to learn how many entries wait. It reads the descriptor port, which reports the head entry's kind, target and byte enables as one packed word and does not remove anything. It then reads the payload port, which returns the head payload and removes the entry. The ports sit in an 8-bit port space with a base of 0xE0.

Top module: `tw_queue_reader`

## Requirements
- R1: A read of the occupancy port at 0xE8 returns the number of queued entries, zero-extended to 32 bits.
- R2: A read of the descriptor port at 0xEA returns the head entry's target number in bits [31:29], its kind in bits [25:24] and its byte enables in bits [3:0]. All other bits read as zero.
- R3: Kind codes are 0 for an address, 1 for a read count and 2 for write data. They are reported in the descriptor exactly as they were pushed.
- R4: A read of the descriptor port, even with the read strobe asserted, removes nothing. Repeated reads between removals return the same value.
- R5: A read of the payload port at 0xEB returns the head payload. When the read strobe is high at a clock edge, that entry is removed. Entries leave in the order they were accepted.
- R6: While the queue is empty, the descriptor and payload ports read as zero. A strobed payload read leaves the queue unchanged.
- R7: An accepted handshake whose target is 0 (configuration) or 3 (expansion ROM) is not queued. It increments the discard counter, which saturates at its maximum value. All other targets are queued.
- R8: `in_ready` is low while the queue holds DEPTH entries. A push offered then is neither stored nor counted.
- R9: A push and a strobed payload read in the same cycle both take effect. The occupancy stays the same, the old head is returned, and the new entry joins the tail.
- R10: Any port address other than 0xE8, 0xEA and 0xEB reads as zero.
- R11: After reset the occupancy is 0, the discard counter is 0 and `in_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Producer offers an entry |
| in_ready | output | 1 | Queue can take an entry this cycle |
| in_kind | input | 2 | Entry kind: 0 address, 1 read count, 2 write data |
| in_target | input | 3 | Target number of the entry |
| in_byte_en | input | 4 | Byte enables of the entry |
| in_payload | input | 32 | Address, count or data word |
| io_addr | input | 8 | Controller port address |
| io_rd | input | 1 | Read strobe; on the payload port it removes the head |
| io_rdata | output | 32 | Read data of the addressed port (combinational) |
| drop_count | output | DROP_W | Saturating count of rejected pushes |

## Verification
A producer push and a controller removal can land on the same clock edge. The bench provokes this by raising `in_valid` and a strobed payload read in the same cycle while one entry is already queued. It judges the result in three ways: the occupancy port must read the same value before and after the edge, the returned word must be the old head, and the next payload read must return the newly pushed word. A second collision occurs when a push arrives while the queue is full. That push must leave the occupancy and the discard counter unchanged.

// File: rtl/tw_pkg.sv
package tw_pkg;
  localparam int PAYLOAD_W = 32;

  typedef enum logic [1:0] {
    KIND_ADDR  = 2'd0,
    KIND_COUNT = 2'd1,
    KIND_WDATA = 2'd2
  } tw_kind_e;

  typedef struct packed {
    logic [1:0]           kind;
    logic [2:0]           target;
    logic [3:0]           byte_en;
    logic [PAYLOAD_W-1:0] payload;
  } tw_entry_t;

  // Targets that never belong in the write queue: configuration and ROM.
  function automatic logic target_rejected(input logic [2:0] tgt);
    return (tgt == 3'd0) || (tgt == 3'd3);
  endfunction

  // Descriptor word: target high, kind in the upper byte, enables low.
  function automatic logic [31:0] pack_descriptor(input tw_entry_t e);
    return {e.target, 3'b000, e.kind, 20'h0_0000, e.byte_en};
  endfunction
endpackage

// File: rtl/tw_filter.sv
module tw_filter #(
  parameter int DROP_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [2:0]        in_target,
  input  logic              room,
  output logic              push_evt,
  output logic              discard_evt,
  output logic [DROP_W-1:0] drop_count
);
  import tw_pkg::*;

  localparam logic [DROP_W-1:0] DROP_MAX = '1;

  logic take;
  assign take        = in_valid && room;
  assign push_evt    = take && !target_rejected(in_target);
  assign discard_evt = take &&  target_rejected(in_target);

  always_ff @(posedge clk) begin
    if (!rst_n)
      drop_count <= '0;
    else if (discard_evt && drop_count != DROP_MAX)
      drop_count <= drop_count + 1'b1;
  end

  // R7
  drop_incr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (discard_evt && drop_count != DROP_MAX) |=> drop_count == $past(drop_count) + 1'b1);
  // R7
  drop_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !discard_evt |=> $stable(drop_count));
  // R7
  push_or_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({push_evt, discard_evt}));
endmodule

// File: rtl/tw_fifo.sv
module tw_fifo #(
  parameter int DEPTH = 8,
  localparam int CNT_W = $clog2(DEPTH + 1),
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push,
  input  tw_pkg::tw_entry_t push_entry,
  input  logic              pop,
  output tw_pkg::tw_entry_t head,
  output logic [CNT_W-1:0]  count,
  output logic              full,
  output logic              empty
);
  import tw_pkg::*;

  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(DEPTH);
  localparam logic [PTR_W-1:0] PTR_LAST = PTR_W'(DEPTH - 1);

  tw_entry_t        store [DEPTH];
  logic [PTR_W-1:0] wr_ptr, rd_ptr;

  function automatic logic [PTR_W-1:0] advance(input logic [PTR_W-1:0] p);
    return (p == PTR_LAST) ? '0 : p + 1'b1;
  endfunction

  assign full  = (count == CNT_FULL);
  assign empty = (count == '0);
  assign head  = store[rd_ptr];

  always_ff @(posedge clk) begin
    if (push) store[wr_ptr] <= push_entry;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push) wr_ptr <= advance(wr_ptr);
      if (pop)  rd_ptr <= advance(rd_ptr);
      case ({push, pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  // R8
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> count != CNT_FULL);
  // R6
  no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> count != '0);
  // R9
  both_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (push && pop) |=> $stable(count));
endmodule

// File: rtl/tw_port_mux.sv
module tw_port_mux #(
  parameter logic [7:0] BASE = 8'hE0,
  parameter int         CNT_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [7:0]        io_addr,
  input  logic              io_rd,
  input  tw_pkg::tw_entry_t head,
  input  logic [CNT_W-1:0]  count,
  input  logic              empty,
  output logic              pop_evt,
  output logic [31:0]       io_rdata
);
  import tw_pkg::*;

  localparam logic [7:0] ADDR_COUNT = 8'(BASE + 8'h08);
  localparam logic [7:0] ADDR_DESC  = 8'(BASE + 8'h0A);
  localparam logic [7:0] ADDR_RECV  = 8'(BASE + 8'h0B);

  assign pop_evt = io_rd && (io_addr == ADDR_RECV) && !empty;

  always_comb begin
    io_rdata = 32'h0;
    unique case (io_addr)
      ADDR_COUNT: io_rdata = 32'(count);
      ADDR_DESC:  io_rdata = empty ? 32'h0 : pack_descriptor(head);
      ADDR_RECV:  io_rdata = empty ? 32'h0 : head.payload;
      default:    io_rdata = 32'h0;
    endcase
  end

  // R2
  desc_spare_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (io_addr == ADDR_DESC) |-> (io_rdata[28:26] == 3'b0 && io_rdata[23:4] == 20'h0));
  // R6
  empty_reads_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (empty && (io_addr == ADDR_RECV || io_addr == ADDR_DESC)) |-> io_rdata == 32'h0);
  // R4
  desc_no_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (io_addr == ADDR_DESC) |-> !pop_evt);
endmodule

// File: rtl/tw_queue_reader.sv
module tw_queue_reader #(
  parameter int         DEPTH  = 8,
  parameter int         DROP_W = 8,
  parameter logic [7:0] BASE   = 8'hE0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [1:0]        in_kind,
  input  logic [2:0]        in_target,
  input  logic [3:0]        in_byte_en,
  input  logic [31:0]       in_payload,
  input  logic [7:0]        io_addr,
  input  logic              io_rd,
  output logic [31:0]       io_rdata,
  output logic [DROP_W-1:0] drop_count
);
  import tw_pkg::*;

  localparam int CNT_W = $clog2(DEPTH + 1);

  tw_entry_t        new_entry, head;
  logic             push_evt, pop_evt, discard_evt;
  logic             full, empty;
  logic [CNT_W-1:0] count;

  assign in_ready  = !full;
  assign new_entry = '{kind: in_kind, target: in_target,
                       byte_en: in_byte_en, payload: in_payload};

  tw_filter #(.DROP_W(DROP_W)) u_filter (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_target(in_target),
    .room(!full), .push_evt(push_evt), .discard_evt(discard_evt),
    .drop_count(drop_count)
  );

  tw_fifo #(.DEPTH(DEPTH)) u_fifo (
    .clk(clk), .rst_n(rst_n), .push(push_evt), .push_entry(new_entry),
    .pop(pop_evt), .head(head), .count(count), .full(full), .empty(empty)
  );

  tw_port_mux #(.BASE(BASE), .CNT_W(CNT_W)) u_mux (
    .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_rd(io_rd),
    .head(head), .count(count), .empty(empty), .pop_evt(pop_evt),
    .io_rdata(io_rdata)
  );

  // R7
  reject_not_queued_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && target_rejected(in_target) && !pop_evt) |=> $stable(count));
endmodule

// File: tb/tw_queue_reader_test.sv
module tw_queue_reader_test;
  localparam int         DEPTH  = 8;
  localparam int         DROP_W = 4;
  localparam logic [7:0] P_CNT  = 8'hE8;
  localparam logic [7:0] P_DESC = 8'hEA;
  localparam logic [7:0] P_RECV = 8'hEB;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic in_ready;
  logic [1:0]  in_kind = '0;
  logic [2:0]  in_target = '0;
  logic [3:0]  in_byte_en = '0;
  logic [31:0] in_payload = '0;
  logic [7:0]  io_addr = '0;
  logic        io_rd = 1'b0;
  logic [31:0] io_rdata;
  logic [DROP_W-1:0] drop_count;

  int checks = 0;
  int errors = 0;
  int exp_drop = 0;
  logic [40:0] model [$];   // {kind, target, byte_en, payload}

  always #2 clk = ~clk;     // 250 MHz

  tw_queue_reader #(.DEPTH(DEPTH), .DROP_W(DROP_W)) uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_kind(in_kind), .in_target(in_target), .in_byte_en(in_byte_en),
    .in_payload(in_payload), .io_addr(io_addr), .io_rd(io_rd),
    .io_rdata(io_rdata), .drop_count(drop_count)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] desc_of(input logic [40:0] e);
    logic [31:0] w = 32'h0;
    w[31:29] = e[38:36];
    w[25:24] = e[40:39];
    w[3:0]   = e[35:32];
    return w;
  endfunction

  task automatic port_rd(input logic [7:0] a, input logic strobe, output logic [31:0] v);
    @(negedge clk);
    io_addr = a; io_rd = strobe;
    #1 v = io_rdata;
    @(posedge clk);
    #1 io_rd = 1'b0;
  endtask

  // Offers one entry for one cycle; updates the model from the rules.
  task automatic push(input logic [1:0] k, input logic [2:0] t,
                      input logic [3:0] be, input logic [31:0] p);
    logic rdy;
    @(negedge clk);
    in_valid = 1'b1; in_kind = k; in_target = t; in_byte_en = be; in_payload = p;
    #1 rdy = (model.size() < DEPTH);
    @(posedge clk);
    #1 in_valid = 1'b0;
    if (rdy) begin
      if (t == 3'd0 || t == 3'd3) begin
        if (exp_drop < (1 << DROP_W) - 1) exp_drop++;
      end else model.push_back({k, t, be, p});
    end
  endtask

  task automatic t_reset;
    logic [31:0] v;
    port_rd(P_CNT, 1'b0, v);
    chk("R11 count after reset", v, 32'd0);
    chk("R11 drop after reset", 32'(drop_count), 32'd0);
    chk("R11 ready after reset", 32'(in_ready), 32'd1);
  endtask

  task automatic t_mixed_drain;
    logic [31:0] v, v2;
    push(2'd0, 3'd2, 4'hF, 32'h0000_1000);
    push(2'd1, 3'd2, 4'h0, 32'd4);
    push(2'd2, 3'd1, 4'h5, 32'hDEAD_BEEF);
    push(2'd2, 3'd4, 4'hA, 32'h1234_5678);
    port_rd(P_CNT, 1'b0, v);
    chk("R1 count after four pushes", v, 32'd4);
    while (model.size() > 0) begin
      port_rd(P_DESC, 1'b1, v);
      chk("R2 R3 descriptor fields", v, desc_of(model[0]));
      port_rd(P_DESC, 1'b1, v2);
      chk("R4 descriptor repeat", v2, v);
      port_rd(P_CNT, 1'b0, v);
      chk("R4 count unchanged by descriptor", v, 32'(model.size()));
      port_rd(P_RECV, 1'b1, v);
      chk("R5 payload in order", v, model[0][31:0]);
      void'(model.pop_front());
      port_rd(P_CNT, 1'b0, v);
      chk("R5 count after removal", v, 32'(model.size()));
    end
  endtask

  task automatic t_empty;
    logic [31:0] v;
    port_rd(P_DESC, 1'b0, v);
    chk("R6 descriptor empty", v, 32'd0);
    port_rd(P_RECV, 1'b1, v);
    chk("R6 payload empty", v, 32'd0);
    port_rd(P_CNT, 1'b0, v);
    chk("R6 count stays zero", v, 32'd0);
    push(2'd2, 3'd2, 4'h3, 32'hCAFE_0001);
    port_rd(P_RECV, 1'b1, v);
    chk("R6 queue intact after empty read", v, 32'hCAFE_0001);
    void'(model.pop_front());
  endtask

  task automatic t_reject;
    logic [31:0] v;
    push(2'd2, 3'd0, 4'hF, 32'h1111_1111);
    push(2'd0, 3'd3, 4'hF, 32'h2222_2222);
    port_rd(P_CNT, 1'b0, v);
    chk("R7 rejected not queued", v, 32'd0);
    chk("R7 drop count", 32'(drop_count), 32'(exp_drop));
    push(2'd0, 3'd7, 4'h1, 32'h3333_3333);
    port_rd(P_RECV, 1'b1, v);
    chk("R7 other target queued", v, 32'h3333_3333);
    void'(model.pop_front());
  endtask

  task automatic t_full;
    logic [31:0] v;
    for (int i = 0; i < DEPTH; i++) push(2'd2, 3'd2, 4'hF, 32'hA000_0000 + 32'(i));
    port_rd(P_CNT, 1'b0, v);
    chk("R8 count at full", v, 32'(DEPTH));
    chk("R8 ready low when full", 32'(in_ready), 32'd0);
    push(2'd2, 3'd2, 4'hF, 32'hBAD0_BAD0);
    push(2'd2, 3'd0, 4'hF, 32'hBAD1_BAD1);
    port_rd(P_CNT, 1'b0, v);
    chk("R8 count unchanged by blocked push", v, 32'(DEPTH));
    chk("R8 drop unchanged when full", 32'(drop_count), 32'(exp_drop));
    for (int i = 0; i < DEPTH; i++) begin
      port_rd(P_RECV, 1'b1, v);
      chk("R8 drain order", v, 32'hA000_0000 + 32'(i));
      void'(model.pop_front());
    end
    port_rd(P_RECV, 1'b0, v);
    chk("R8 nothing extra stored", v, 32'd0);
  endtask

  task automatic t_both;
    logic [31:0] v;
    push(2'd2, 3'd4, 4'h1, 32'h0000_00A1);
    @(negedge clk);
    in_valid = 1'b1; in_kind = 2'd2; in_target = 3'd1; in_byte_en = 4'h2;
    in_payload = 32'h0000_00B2; io_addr = P_RECV; io_rd = 1'b1;
    #1 v = io_rdata;
    @(posedge clk);
    #1 in_valid = 1'b0; io_rd = 1'b0;
    chk("R9 old head returned", v, 32'h0000_00A1);
    port_rd(P_CNT, 1'b0, v);
    chk("R9 count unchanged", v, 32'd1);
    port_rd(P_RECV, 1'b1, v);
    chk("R9 new entry at tail", v, 32'h0000_00B2);
    model.delete();
  endtask

  task automatic t_unmapped;
    logic [31:0] v;
    push(2'd2, 3'd2, 4'hF, 32'hFFFF_FFFF);
    port_rd(8'hE9, 1'b1, v);
    chk("R10 addr E9", v, 32'd0);
    port_rd(8'h0B, 1'b1, v);
    chk("R10 addr 0B", v, 32'd0);
    port_rd(8'hEC, 1'b1, v);
    chk("R10 addr EC", v, 32'd0);
    port_rd(P_CNT, 1'b0, v);
    chk("R10 unmapped read removes nothing", v, 32'd1);
    port_rd(P_RECV, 1'b1, v);
    void'(model.pop_front());
  endtask

  task automatic t_saturate;
    for (int i = 0; i < 20; i++) push(2'd1, 3'd3, 4'h0, 32'(i));
    chk("R7 drop saturates", 32'(drop_count), 32'((1 << DROP_W) - 1));
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    t_reset();
    t_mixed_drain();
    t_empty();
    t_reject();
    t_full();
    t_both();
    t_unmapped();
    t_saturate();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule